// File: doc/BRIEF.md
# SPI Master Transfer Engine with Buffer Policies

This block is a single-word SPI master. A small register port holds a control word, a one-word transmit buffer, a one-word receive buffer and a status word. Software does not issue an explicit "go". A transfer starts as a side effect of a register access. The control word chooses which access starts it: a read of the receive buffer or a write to the transmit buffer. Each transfer moves one 16-bit word in SPI mode 0 while the chip select is held low.

Two policy bits decide what happens when software falls behind. If a transfer starts while the transmit buffer is empty, the engine sends either an all-zero word or the word it sent most recently. If a word arrives while the receive buffer is still unread, it either replaces the old word or is dropped.

The interrupt output is a level. Its meaning depends on the mode: "receive word waiting" in read-triggered mode, "transmit buffer free" in write-triggered mode. Software uses it to pace the accesses that start the next transfer.

Top module: `spi_xfer_master`

## Requirements
- R1: Out of reset, chip select is high, SCLK is low, busy is low, the interrupt is low, and the status word reads 0x0004 (transmit buffer empty, receive buffer empty, idle). The control word resets to mode 00 with baud value 4.
- R2: In mode 01, a write to the transmit buffer while idle starts one transfer of the written word. In this mode the interrupt is high exactly while the transmit buffer is empty, and a write to the transmit buffer drops it on the next cycle.
- R3: In mode 00, a read of the receive buffer while idle starts one transfer, and a transmit write does not start one. In this mode the interrupt is high exactly while the receive buffer holds an unread word, and a read of the receive buffer while idle drops it on the next cycle.
- R4: A trigger access made while busy starts no transfer and is not remembered. The access itself completes normally: a written word is stored and later read back at address 1, and a read returns the current receive word.
- R5: With the send-zero bit (control bit 2) set, a transfer started with an empty transmit buffer shifts out 0x0000.
- R6: With the send-zero bit clear, a transfer started with an empty transmit buffer shifts out again the most recently shifted-out word.
- R7: With the overwrite bit (control bit 3) set, a word received while the receive buffer is unread replaces the buffer contents.
- R8: With the overwrite bit clear, a word received while the receive buffer is unread is dropped, and the buffer stays unchanged and still full.
- R9: Mode codes 10 and 11 start no transfer on any access and hold the interrupt low.
- R10: A frame is 16 bits, MSB first, in SPI mode 0. SCLK idles low. MOSI changes only on falling edges and is stable while SCLK is high. MISO is sampled on rising edges, and the sampled bits form the received word MSB first.
- R11: Each SCLK half period lasts N system clocks, where N is control bits 15:8 latched at the start of the transfer. Values 0 and 1 behave as 2.
- R12: Chip select falls on the clock edge that takes the trigger. The first rising SCLK edge follows N clocks later, and chip select rises N clocks after the last falling edge. Busy is high from the trigger edge until chip select rises.
- R13: Register map: address 0 is control (bits 1:0 mode, bit 2 send-zero, bit 3 overwrite, bits 15:8 baud). Address 1 is the transmit buffer. Address 2 is the receive buffer. Address 3 is status (bit 0 busy, bit 1 receive full, bit 2 transmit empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_rd_i | input | 1 | Register read strobe, one cycle |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level interrupt; meaning depends on mode |
| busy_o | output | 1 | High from the trigger until chip select is released |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
The bench targets accesses made while a frame is still shifting. A design that queued such a trigger would emit a second frame. A design that discarded the access itself would lose the buffered word. Each underrun policy is checked against a tracked "last word sent" value, so a design that resent the stale buffer, or sent zeros when it should have repeated, gives a wrong MOSI capture. Back-to-back receptions without a read separate overwrite from discard, and an engine that always overwrites shows the newer word. SCLK gaps and the lead and tail of chip select are measured in clocks, including baud values 0 and 1, so an off-by-one in the divider or a missing clamp shows up.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    MODE_RD_TRIG = 2'b00,
    MODE_WR_TRIG = 2'b01,
    MODE_OFF_A   = 2'b10,
    MODE_OFF_B   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } eng_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_RX   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTRL_BAUD_LSB = 8;
endpackage

// File: rtl/spi_xfer_regs.sv
module spi_xfer_regs
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BAUD_W     = 8,
  parameter int BAUD_RESET = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              start_o,
  output logic [DATA_W-1:0] start_word_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              irq_o
);
  xfer_mode_e        mode_q;
  logic              zero_q, ovr_q;
  logic [BAUD_W-1:0] baud_q;
  logic [DATA_W-1:0] tx_buf_q, rx_buf_q, last_q;
  logic              tx_empty_q, tx_refill_q, rx_full_q;
  logic              wr_ctrl, wr_tx, rd_rx;
  logic [DATA_W-1:0] ctrl_rd, stat_rd;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_tx   = wr_i && (addr_i == ADDR_TX);
  assign rd_rx   = rd_i && (addr_i == ADDR_RX);

  assign start_o = !busy_i &&
                   (((mode_q == MODE_RD_TRIG) && rd_rx) ||
                    ((mode_q == MODE_WR_TRIG) && wr_tx));

  // word for a new frame: fresh write, buffered word, or underrun fill
  always_comb begin
    if (wr_tx)            start_word_o = wdata_i;
    else if (!tx_empty_q) start_word_o = tx_buf_q;
    else if (zero_q)      start_word_o = '0;
    else                  start_word_o = last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RD_TRIG;
      zero_q <= 1'b0;
      ovr_q  <= 1'b0;
      baud_q <= BAUD_W'(BAUD_RESET);
    end else if (wr_ctrl) begin
      mode_q <= xfer_mode_e'(wdata_i[1:0]);
      zero_q <= wdata_i[2];
      ovr_q  <= wdata_i[3];
      baud_q <= wdata_i[CTRL_BAUD_LSB +: BAUD_W];
    end
  end

  // transmit buffer stays occupied until its frame completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q    <= '0;
      tx_empty_q  <= 1'b1;
      tx_refill_q <= 1'b0;
      last_q      <= '0;
    end else begin
      if (done_i) begin
        if (!tx_refill_q) tx_empty_q <= 1'b1;
        tx_refill_q <= 1'b0;
      end
      if (start_o) begin
        last_q      <= start_word_o;
        tx_refill_q <= 1'b0;
      end
      if (wr_tx) begin
        tx_buf_q    <= wdata_i;
        tx_empty_q  <= 1'b0;
        tx_refill_q <= busy_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
    end else begin
      if (rd_rx) rx_full_q <= 1'b0;
      if (done_i && (!rx_full_q || ovr_q)) begin
        rx_buf_q  <= rx_word_i;
        rx_full_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_rd                            = '0;
    ctrl_rd[1:0]                       = mode_q;
    ctrl_rd[2]                         = zero_q;
    ctrl_rd[3]                         = ovr_q;
    ctrl_rd[CTRL_BAUD_LSB +: BAUD_W]   = baud_q;
    stat_rd                            = '0;
    stat_rd[0]                         = busy_i;
    stat_rd[1]                         = rx_full_q;
    stat_rd[2]                         = tx_empty_q;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_rd;
      ADDR_TX:   rdata_o = tx_buf_q;
      ADDR_RX:   rdata_o = rx_buf_q;
      default:   rdata_o = stat_rd;
    endcase
  end

  always_comb begin
    unique case (mode_q)
      MODE_RD_TRIG: irq_o = rx_full_q;
      MODE_WR_TRIG: irq_o = tx_empty_q;
      default:      irq_o = 1'b0;
    endcase
  end

  assign baud_o = baud_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int                 N_EDGES   = 2 * DATA_W;
  localparam int                 EDGE_W    = $clog2(N_EDGES);
  localparam logic [EDGE_W-1:0]  LAST_EDGE = EDGE_W'(N_EDGES - 1);
  localparam logic [BAUD_W-1:0]  MIN_HALF  = BAUD_W'(2);

  eng_state_e        state_q;
  logic [BAUD_W-1:0] cnt_q, half_q, eff_half;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic              sclk_q, tick;

  assign eff_half = (baud_i < MIN_HALF) ? MIN_HALF : baud_i;
  assign tick     = (cnt_q == half_q - BAUD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= MIN_HALF;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sclk_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
            edge_q  <= '0;
            half_q  <= eff_half;
            tx_sh_q <= word_i;
            sclk_q  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (!sclk_q) rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
            else         tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            if (edge_q == LAST_EDGE) state_q <= ST_TAIL;
          end else begin
            cnt_q <= cnt_q + BAUD_W'(1);
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + BAUD_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign cs_no     = (state_q == ST_IDLE);
  assign sclk_o    = sclk_q;
  assign mosi_o    = (state_q == ST_SHIFT) ? tx_sh_q[DATA_W-1] : 1'b0;
  assign done_o    = (state_q == ST_TAIL) && tick;
  assign rx_word_o = rx_sh_q;
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  input  logic              miso_i
);
  logic              start_w, done_w, busy_w;
  logic [DATA_W-1:0] start_word_w, rx_word_w;
  logic [BAUD_W-1:0] baud_w;

  spi_xfer_regs #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (reg_addr_i),
    .wr_i         (reg_wr_i),
    .rd_i         (reg_rd_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .busy_i       (busy_w),
    .done_i       (done_w),
    .rx_word_i    (rx_word_w),
    .start_o      (start_w),
    .start_word_o (start_word_w),
    .baud_o       (baud_w),
    .irq_o        (irq_o)
  );

  spi_xfer_engine #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .word_i    (start_word_w),
    .baud_i    (baud_w),
    .miso_i    (miso_i),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .cs_no     (cs_no),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .rx_word_o (rx_word_w)
  );

  assign busy_o = busy_w;
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] reg_addr_i,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic [1:0] ctl_mode_i,
  input logic       irq_o,
  input logic       busy_o,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic       cs_no,
  input logic       start_i,
  input logic       done_i
);
  logic [1:0] mode_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            mode_sh <= 2'b00;
    else if (reg_wr_i && reg_addr_i == 2'd0) mode_sh <= ctl_mode_i;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R10
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R10
  AST_START_TAKES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && !cs_no)); // R12
  AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R4
  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (cs_no && !busy_o)); // R12
  AST_IRQ_OFF_MODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_sh[1] |-> !irq_o); // R9
  AST_IRQ_WR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sh == 2'b01 && reg_wr_i && reg_addr_i == 2'd1) |=> !irq_o); // R2
  AST_IRQ_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sh == 2'b00 && reg_rd_i && reg_addr_i == 2'd2 && !busy_o) |=> !irq_o); // R3
endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .ctl_mode_i (reg_wdata_i[1:0]),
  .irq_o      (irq_o),
  .busy_o     (busy_o),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no),
  .start_i    (start_w),
  .done_i     (done_w)
);

// File: tb/sim_spi_xfer_master.sv
`timescale 1ns/1ps
module sim_spi_xfer_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        irq, busy, sclk, mosi, cs_n;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  spi_xfer_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .busy_o(busy),
    .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n), .miso_i(miso)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int exp_n = 4;
  logic [15:0] slv = '0, sh = '0, cap = '0, last_cap = '0;
  int nbits = 0, last_bits = 0, t_last = 0, tail = 0, frames = 0;
  bit gap_bad = 0, last_gap_bad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and edge timing monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      sh = slv; miso = sh[15]; t_last = cyc; gap_bad = 0; cap = '0; nbits = 0;
    end
    if (!cs_n && !prev_sclk && sclk) begin
      cap = {cap[14:0], mosi}; nbits++;
      if (cyc - t_last != exp_n) gap_bad = 1;
      t_last = cyc;
    end
    if (!cs_n && prev_sclk && !sclk) begin
      sh = sh << 1; miso = sh[15];
      if (cyc - t_last != exp_n) gap_bad = 1;
      t_last = cyc;
    end
    if (!prev_cs && cs_n) begin
      frames++; last_cap = cap; last_bits = nbits; tail = cyc - t_last; last_gap_bad = gap_bad;
    end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  function automatic logic [15:0] ctrl(input logic [1:0] m, input bit z, input bit o, input logic [7:0] b);
    return {b, 4'b0, o, z, m};
  endfunction

  function automatic int eff(input int b);
    return (b < 2) ? 2 : b;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 20000) begin @(negedge clk); g++; end
    if (busy) chk("R12 busy stuck", 1, 0);
    @(negedge clk);
  endtask

  task automatic set_ctrl(input logic [1:0] m, input bit z, input bit o, input int b);
    wr_reg(2'd0, ctrl(m, z, o, 8'(b)));
    exp_n = eff(b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d, last_sent, w, s;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs", cs_n, 1); chk("R1 sclk", sclk, 0);
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0);
    rd_reg(2'd3, d); chk("R1 R13 status", d, 16'h0004);
    rd_reg(2'd0, d); chk("R1 R13 ctrl", d, 16'h0400);

    // R2 write-triggered
    set_ctrl(2'b01, 0, 0, 2);
    chk("R2 irq tx empty", irq, 1);
    slv = 16'h3C5A;
    wr_reg(2'd1, 16'hA5C3);
    chk("R12 busy at trigger", busy, 1); chk("R12 cs low", cs_n, 0);
    chk("R2 irq cleared", irq, 0);
    wait_idle();
    chk("R2 R10 mosi word", last_cap, 16'hA5C3); chk("R10 bits", last_bits, 16);
    chk("R11 gaps", last_gap_bad, 0); chk("R12 tail", tail, 2);
    chk("R2 irq back", irq, 1);
    rd_reg(2'd2, d); chk("R10 rx word", d, 16'h3C5A);
    last_sent = 16'hA5C3;

    // R3 read-triggered
    set_ctrl(2'b00, 0, 0, 3);
    chk("R3 irq empty rx", irq, 0);
    f0 = frames;
    wr_reg(2'd1, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R3 write no start", frames - f0 + int'(busy), 0);
    slv = 16'hBEEF;
    rd_reg(2'd2, d);
    chk("R3 read starts", busy, 1);
    wait_idle();
    chk("R3 mosi", last_cap, 16'h1234); chk("R3 irq rx full", irq, 1);
    chk("R11 gaps n3", last_gap_bad, 0); chk("R12 tail n3", tail, 3);
    last_sent = 16'h1234;
    slv = 16'h0F0F;
    rd_reg(2'd2, d);
    chk("R3 read data", d, 16'hBEEF); chk("R3 irq cleared", irq, 0);
    wait_idle();
    chk("R6 repeat last", last_cap, last_sent);

    // R5 zero fill
    set_ctrl(2'b00, 1, 0, 3);
    slv = 16'h4444;
    rd_reg(2'd2, d);
    chk("R3 data", d, 16'h0F0F);
    wait_idle();
    chk("R5 zeros", last_cap, 16'h0000);

    // R4 trigger while busy
    set_ctrl(2'b01, 0, 0, 4);
    f0 = frames;
    rd_reg(2'd2, d);
    chk("R4 mode01 read no start", frames - f0 + int'(busy), 0);
    slv = 16'h1111;
    wr_reg(2'd1, 16'hC001);
    repeat (3) @(negedge clk);
    wr_reg(2'd1, 16'hD00D);
    wait_idle();
    chk("R4 one frame", frames - f0, 1); chk("R4 first word", last_cap, 16'hC001);
    rd_reg(2'd1, d); chk("R4 write kept", d, 16'hD00D);
    chk("R4 irq refilled", irq, 0);
    set_ctrl(2'b00, 0, 0, 4);
    f0 = frames;
    slv = 16'h2222;
    rd_reg(2'd2, d); chk("R4 rx before", d, 16'h1111);
    rd_reg(2'd2, d); chk("R4 read while busy", d, 16'h1111);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R4 no queued frame", frames - f0, 1); chk("R4 sent buffer", last_cap, 16'hD00D);

    // R8 discard / R7 overwrite
    set_ctrl(2'b01, 0, 0, 2);
    rd_reg(2'd2, d); chk("R4 late rx", d, 16'h2222);
    slv = 16'hAAAA; wr_reg(2'd1, 16'h0001); wait_idle();
    slv = 16'h5555; wr_reg(2'd1, 16'h0002); wait_idle();
    rd_reg(2'd3, d); chk("R8 still full", d[1], 1);
    rd_reg(2'd2, d); chk("R8 discard", d, 16'hAAAA);
    set_ctrl(2'b01, 0, 1, 2);
    slv = 16'h6666; wr_reg(2'd1, 16'h0003); wait_idle();
    slv = 16'h7777; wr_reg(2'd1, 16'h0004); wait_idle();
    rd_reg(2'd2, d); chk("R7 overwrite", d, 16'h7777);

    // R9 inert modes
    for (int m = 2; m < 4; m++) begin
      set_ctrl(2'(m), 0, 0, 2);
      f0 = frames;
      wr_reg(2'd1, 16'h0099);
      chk("R9 irq low", irq, 0);
      rd_reg(2'd2, d);
      repeat (4) @(negedge clk);
      chk("R9 no frame", frames - f0 + int'(busy), 0);
    end

    // R11 clamp
    for (int b = 0; b < 2; b++) begin
      set_ctrl(2'b01, 0, 1, b);
      slv = 16'h8001; wr_reg(2'd1, 16'h8421); wait_idle();
      chk("R11 clamp gaps", last_gap_bad, 0); chk("R11 clamp tail", tail, 2);
      chk("R10 clamp word", last_cap, 16'h8421);
    end

    // random frames
    void'($urandom(32'h5EED));
    for (int i = 0; i < 24; i++) begin
      set_ctrl(2'b01, 0, 1, 2 + int'($urandom_range(0, 3)));
      w = 16'($urandom); s = 16'($urandom);
      slv = s; wr_reg(2'd1, w); wait_idle();
      chk("R10 rand mosi", last_cap, w);
      chk("R11 rand gaps", last_gap_bad, 0);
      chk("R12 rand tail", tail, exp_n);
      rd_reg(2'd2, d); chk("R10 rand rx", d, s);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule